// File: doc/BRIEF.md
# Burst-of-Four Pipelined Read Port

This block is the read side of a memory with separate read and write ports and double-data-rate data. Each address selects a line of four words held side by side, so the address has two bits fewer than a word-addressed array of the same size would need. A read request is a low level on `rd_sel_n`, sampled only on a main-clock rising edge. The line it selects comes back as four words on consecutive half-cycles, lowest-order word first.

The half-cycle timing uses a single clock `clk` at twice the main-clock rate. An internal phase flag marks which `clk` edges stand for main-clock rising edges, and it is shown on `k_rise`. A request needs two main cycles of output time. A second request on the very next main-clock rise after an accepted one is dropped. Requests on every other rise are accepted and give an unbroken stream of words. `half_lat` sets the latency: 1.5 main cycles when high, 1 main cycle when low. It must stay steady while a burst is pending.

The output side is a stream with no back-pressure. `q_valid` marks each word and is a valid flag with no ready. The consumer must take every word on the tick it appears, and a burst cannot be stalled once accepted. `q_oe` enables the external tristate driver. It rises with the first word and falls only after the last pending word, on a main-clock rise. A plain line-wide write port fills the shared storage.

Top module: `burst4_rd_port`

## Requirements
- R1: While reset is asserted and on the first ticks after it, `q_valid` and `q_oe` are low (port deselected, bus released).
- R2: A request is accepted only on a `clk` edge at which `k_rise` is 1 and `rd_sel_n` is 0. `rd_addr` is captured at that edge.
- R3: An accepted request produces exactly four words on four consecutive ticks with `q_valid` high. Word k is bits [k*WORD_W +: WORD_W] of the stored line, and word 0 comes first.
- R4: With `half_lat`=1, the first word is on `q` after the third `clk` edge following the accepting edge, and `q_valid` is low after the first and second.
- R5: With `half_lat`=0, the first word is on `q` after the second `clk` edge following the accepting edge.
- R6: A request at the main-clock rise directly after an accepting rise is ignored: none of its line's words are output.
- R7: Requests accepted on every other main-clock rise give back-to-back bursts with `q_valid` high without a gap.
- R8: `q_oe` is high whenever `q_valid` is high. After the last word, `q_oe` falls at the first main-clock rise edge with no word launched. With `half_lat`=1 it is still high one tick after the last word and low two ticks after. With `half_lat`=0 it is low one tick after.
- R9: A low `rd_sel_n` at an edge where `k_rise` is 0 has no effect: no word is output and `q_oe` stays low.
- R10: A line written through `wr_en`/`wr_addr`/`wr_line` is returned by a later read of that address, including after an overwrite.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Double-rate clock; two ticks per main cycle |
| rst_n | input | 1 | Synchronous reset, active low |
| half_lat | input | 1 | 1: 1.5-cycle latency, 0: 1-cycle latency |
| k_rise | output | 1 | High when the next `clk` edge is a main-clock rise |
| rd_sel_n | input | 1 | Read request, active low |
| rd_addr | input | ADDR_W | Line address of the read |
| wr_en | input | 1 | Write a whole line at this edge |
| wr_addr | input | ADDR_W | Line address of the write |
| wr_line | input | 4*WORD_W | Line data, word 0 in the low bits |
| q | output | WORD_W | Output word |
| q_valid | output | 1 | `q` carries a burst word this tick |
| q_oe | output | 1 | Output driver enable |

## Verification
The hardest case to reach is two pipelined bursts, where a third request falls on the blocked rise in between and must vanish. Meanwhile the second burst must follow the first without a gap. The stimulus keeps `rd_sel_n` low across three consecutive main-clock rises and changes the address on each. Each line holds a distinct pattern, so any word from the dropped line, or a one-tick slip, shows up as a data mismatch. A second hard case is a request placed on the off-phase edge, which is reached by waiting until `k_rise` reads 0 before driving.

// File: rtl/b4_pkg.sv
package b4_pkg;
  localparam int unsigned BEATS  = 4;
  localparam int unsigned BEAT_W = $clog2(BEATS);

  typedef enum logic {
    LAT_ONE      = 1'b0,
    LAT_ONE_HALF = 1'b1
  } lat_mode_e;

  // ticks to wait after the accepting edge, minus one, before launch
  function automatic logic [1:0] lead_ticks(input lat_mode_e m);
    return (m == LAT_ONE_HALF) ? 2'd2 : 2'd1;
  endfunction
endpackage

// File: rtl/b4_phase.sv
module b4_phase (
  input  logic clk,
  input  logic rst_n,
  output logic kph
);
  // kph=1 means the coming edge is a main-clock rise
  always_ff @(posedge clk) begin
    if (!rst_n) kph <= 1'b0;
    else        kph <= ~kph;
  end
endmodule

// File: rtl/b4_req_gate.sv
module b4_req_gate
  import b4_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  logic      kph,
  input  logic      rd_sel_n,
  input  logic      half_lat,
  output logic      acc,
  output lat_mode_e acc_mode
);
  logic blk;

  assign acc      = kph & ~rd_sel_n & ~blk;
  assign acc_mode = half_lat ? LAT_ONE_HALF : LAT_ONE;

  // one main-cycle lockout after each accepted request
  always_ff @(posedge clk) begin
    if (!rst_n)   blk <= 1'b0;
    else if (kph) blk <= acc;
  end
endmodule

// File: rtl/b4_line_store.sv
module b4_line_store #(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                           clk,
  input  logic                           wr_en,
  input  logic [ADDR_W-1:0]              wr_addr,
  input  logic [b4_pkg::BEATS*WORD_W-1:0] wr_line,
  input  logic                           rd_en,
  input  logic [ADDR_W-1:0]              rd_addr,
  output logic [b4_pkg::BEATS*WORD_W-1:0] rd_line
);
  localparam int unsigned DEPTH  = 1 << ADDR_W;
  localparam int unsigned LINE_W = b4_pkg::BEATS * WORD_W;

  logic [LINE_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_line;
  end

  // registered read, old data on a same-edge write
  always_ff @(posedge clk) begin
    if (rd_en) rd_line <= mem[rd_addr];
  end
endmodule

// File: rtl/b4_beat_seq.sv
module b4_beat_seq
  import b4_pkg::*;
#(
  parameter int unsigned WORD_W = 18
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    kph,
  input  logic                    acc,
  input  lat_mode_e               acc_mode,
  input  logic [BEATS*WORD_W-1:0] line_in,
  output logic [WORD_W-1:0]       q,
  output logic                    q_valid,
  output logic                    q_oe
);
  localparam int unsigned LINE_W = BEATS * WORD_W;

  logic              pend;
  logic [1:0]        wcnt;
  logic              active;
  logic [BEAT_W-1:0] beat;
  logic [LINE_W-1:0] obuf;
  logic              launch;

  assign launch = pend && (wcnt == 2'd0);

  // latency countdown between acceptance and first word
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend <= 1'b0;
      wcnt <= 2'd0;
    end else if (acc) begin
      pend <= 1'b1;
      wcnt <= lead_ticks(acc_mode);
    end else if (launch) begin
      pend <= 1'b0;
    end else if (pend) begin
      wcnt <= wcnt - 2'd1;
    end
  end

  // beat shifter and output enable
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active  <= 1'b0;
      beat    <= '0;
      obuf    <= '0;
      q       <= '0;
      q_valid <= 1'b0;
      q_oe    <= 1'b0;
    end else if (launch) begin
      obuf    <= line_in;
      q       <= line_in[WORD_W-1:0];
      beat    <= BEAT_W'(1);
      active  <= 1'b1;
      q_valid <= 1'b1;
      q_oe    <= 1'b1;
    end else if (active) begin
      q       <= obuf[beat*WORD_W +: WORD_W];
      beat    <= beat + BEAT_W'(1);
      active  <= (beat != BEAT_W'(BEATS-1));
      q_valid <= 1'b1;
    end else begin
      q_valid <= 1'b0;
      if (kph) q_oe <= 1'b0;
    end
  end
endmodule

// File: rtl/burst4_rd_port.sv
module burst4_rd_port
  import b4_pkg::*;
#(
  parameter int unsigned WORD_W = 18,
  parameter int unsigned ADDR_W = 6
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    half_lat,
  output logic                    k_rise,
  input  logic                    rd_sel_n,
  input  logic [ADDR_W-1:0]       rd_addr,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BEATS*WORD_W-1:0] wr_line,
  output logic [WORD_W-1:0]       q,
  output logic                    q_valid,
  output logic                    q_oe
);
  localparam int unsigned LINE_W = BEATS * WORD_W;

  logic              kph;
  logic              acc;
  lat_mode_e         acc_mode;
  logic [LINE_W-1:0] line_q;

  assign k_rise = kph;

  b4_phase u_phase (.clk(clk), .rst_n(rst_n), .kph(kph));

  b4_req_gate u_gate (
    .clk(clk), .rst_n(rst_n), .kph(kph), .rd_sel_n(rd_sel_n),
    .half_lat(half_lat), .acc(acc), .acc_mode(acc_mode)
  );

  b4_line_store #(.WORD_W(WORD_W), .ADDR_W(ADDR_W)) u_store (
    .clk(clk), .wr_en(wr_en), .wr_addr(wr_addr), .wr_line(wr_line),
    .rd_en(acc), .rd_addr(rd_addr), .rd_line(line_q)
  );

  b4_beat_seq #(.WORD_W(WORD_W)) u_seq (
    .clk(clk), .rst_n(rst_n), .kph(kph), .acc(acc), .acc_mode(acc_mode),
    .line_in(line_q), .q(q), .q_valid(q_valid), .q_oe(q_oe)
  );
endmodule

// File: rtl/b4_rd_chk.sv
module b4_rd_chk (
  input logic clk,
  input logic rst_n,
  input logic kph,
  input logic acc,
  input logic q_valid,
  input logic q_oe
);
  logic [1:0] run;

  always_ff @(posedge clk) begin
    if (!rst_n)       run <= 2'd0;
    else if (q_valid) run <= run + 2'd1;
  end

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!q_valid && !q_oe));

  a_r2_accept_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    acc |-> kph);

  a_r6_next_rise_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> ##1 !acc);

  a_r3_whole_bursts: assert property (@(posedge clk) disable iff (!rst_n)
    !q_valid |-> (run == 2'd0));

  a_r8_valid_needs_oe: assert property (@(posedge clk) disable iff (!rst_n)
    q_valid |-> q_oe);

  a_r8_release_on_rise: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(q_oe) |-> $past(kph));
endmodule

bind burst4_rd_port b4_rd_chk u_chk (
  .clk(clk), .rst_n(rst_n), .kph(kph), .acc(acc),
  .q_valid(q_valid), .q_oe(q_oe)
);

// File: tb/sim_burst4_rd_port.sv
`timescale 1ns/1ps
module sim_burst4_rd_port;
  localparam int W  = 18;
  localparam int AW = 6;

  logic clk = 0, rst_n = 0, half_lat = 1, rd_sel_n = 1, wr_en = 0;
  logic [AW-1:0]  rd_addr = '0, wr_addr = '0;
  logic [4*W-1:0] wr_line = '0;
  logic           k_rise, q_valid, q_oe;
  logic [W-1:0]   q;
  int checks = 0, fails = 0;

  always #2 clk = ~clk;

  burst4_rd_port #(.WORD_W(W), .ADDR_W(AW)) u0 (
    .clk(clk), .rst_n(rst_n), .half_lat(half_lat), .k_rise(k_rise),
    .rd_sel_n(rd_sel_n), .rd_addr(rd_addr), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_line(wr_line), .q(q), .q_valid(q_valid), .q_oe(q_oe)
  );

  function automatic logic [W-1:0] pat(input int a, input int k, input int salt);
    return W'(a * 613 + k * 71 + salt * 4099 + 5);
  endfunction

  task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_line(input int a, input int salt);
    @(negedge clk);
    wr_en = 1; wr_addr = AW'(a);
    for (int k = 0; k < 4; k++) wr_line[k*W +: W] = pat(a, k, salt);
    tick();
    wr_en = 0;
  endtask

  task automatic wait_rise();
    @(negedge clk);
    while (k_rise !== 1'b1) @(negedge clk);
  endtask

  task automatic t_reset_state();
    chk(q_valid === 1'b0, "R1 q_valid in reset", q_valid, 0);
    chk(q_oe === 1'b0, "R1 q_oe in reset", q_oe, 0);
    @(negedge clk); rst_n = 1;
    tick(); tick();
    chk(q_valid === 1'b0 && q_oe === 1'b0, "R1 idle after reset", {q_valid, q_oe}, 0);
  endtask

  // single read; checks latency (R4/R5), order (R3), release (R8), data (R2/R10)
  task automatic t_single(input int a, input int salt, input logic mode);
    int lat;
    lat = mode ? 3 : 2;
    half_lat = mode;
    wait_rise();
    rd_sel_n = 0; rd_addr = AW'(a);
    tick();
    rd_sel_n = 1; rd_addr = ~AW'(a);
    for (int i = 1; i < lat; i++) begin
      tick();
      chk(q_valid === 1'b0, mode ? "R4 no word before latency" : "R5 no word before latency", q_valid, 0);
    end
    for (int k = 0; k < 4; k++) begin
      tick();
      chk(q_valid === 1'b1 && q === pat(a, k, salt),
          mode ? "R3 R4 R10 word order" : "R3 R5 R10 word order", q, pat(a, k, salt));
    end
    tick();
    chk(q_valid === 1'b0, "R3 valid ends after four", q_valid, 0);
    chk(q_oe === mode, "R8 oe one tick after last", q_oe, mode);
    tick();
    chk(q_oe === 1'b0, "R8 oe released", q_oe, 0);
  endtask

  // three consecutive rise requests: A accepted, B dropped, C accepted
  task automatic t_back_to_back(input int a, input int b, input int c, input int salt);
    half_lat = 1;
    wait_rise();
    rd_sel_n = 0; rd_addr = AW'(a);
    tick();
    rd_addr = AW'(b);
    tick(); tick();
    rd_addr = AW'(c);
    for (int k = 3; k <= 10; k++) begin
      tick();
      if (k == 4) begin rd_sel_n = 1; rd_addr = '0; end
      if (k < 7)
        chk(q_valid === 1'b1 && q === pat(a, k-3, salt), "R6 R7 first burst", q, pat(a, k-3, salt));
      else
        chk(q_valid === 1'b1 && q === pat(c, k-7, salt), "R6 R7 second burst gapless", q, pat(c, k-7, salt));
    end
    tick();
    chk(q_valid === 1'b0, "R6 no burst from dropped request", q_valid, 0);
    tick(); tick();
    chk(q_valid === 1'b0 && q_oe === 1'b0, "R6 R8 idle after pair", {q_valid, q_oe}, 0);
  endtask

  task automatic t_off_phase(input int a);
    half_lat = 1;
    @(negedge clk);
    while (k_rise !== 1'b0) @(negedge clk);
    rd_sel_n = 0; rd_addr = AW'(a);
    tick();
    rd_sel_n = 1;
    for (int i = 0; i < 8; i++) begin
      tick();
      chk(q_valid === 1'b0 && q_oe === 1'b0, "R9 off-phase request ignored", {q_valid, q_oe}, 0);
    end
  endtask

  initial begin
    #(4 * 20000);
    fails++;
    $display("FAIL watchdog actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset_state();
    for (int a = 0; a < 8; a++) write_line(a, 0);
    t_single(3, 0, 1'b1);
    t_single(5, 0, 1'b0);
    write_line(5, 1);
    t_single(5, 1, 1'b1);
    t_back_to_back(1, 2, 6, 0);
    t_off_phase(4);
    t_single(7, 0, 1'b0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule